// File: doc/BRIEF.md
# Parallel DDR ADC Capture Unit

This block rebuilds full-width converter samples from a parallel double-data-rate bus. It sits behind the input DDR registers, so it sees one word per clock that came in on the rising edge and one that came in on the falling edge. From these it produces samples in the capture clock domain. It is built with the resolution as a parameter, which must be an even value from 12 to 16 bits.

Two formats are supported, and only one is active at any time. In the bit-interleaved format, half as many lanes as sample bits are used. The even-indexed bits of a sample come in on the rising edge and the odd-indexed bits come in on the falling edge. One sample comes out per clock. In the sample-per-edge format, the bus has one lane per sample bit, and each edge carries a complete sample. The block then delivers two samples per clock, earliest first, under a single valid strobe.

The format is set by configuration and is never detected from the data. It is latched while the synchronous reset is held. The output stage carries one register of latency.

Top module: `ddr_adc_capture`

## Requirements
- R1: While `srst` is high at a rising edge, that edge clears `smp_valid`, `smp_early` and `smp_late` to zero.
- R2: After `srst` falls, the first rising edge leaves `smp_valid` low. `smp_valid` goes high from the second rising edge on.
- R3: `fmt_sel` is sampled only at edges where `srst` is high (0 = bit-interleaved, 1 = sample-per-edge). Changes of `fmt_sel` while `srst` is low have no effect on the outputs.
- R4: In bit-interleaved format, sample bit 2k equals `din_rise[k]` and bit 2k+1 equals `din_fall[k]`, for k from 0 to RES/2-1. The sample appears on `smp_early` one rising edge after the lanes are captured.
- R5: In bit-interleaved format, lanes RES/2 to RES-1 of both halves are ignored, and `smp_late` is zero.
- R6: In sample-per-edge format, `smp_early` equals `din_rise` and `smp_late` equals `din_fall`, with one edge of latency.
- R7: Once valid, `smp_valid` stays high on every cycle until `srst` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| srst | input | 1 | Synchronous reset, active high; also the window in which the format is latched |
| fmt_sel | input | 1 | Format select: 0 bit-interleaved, 1 sample-per-edge |
| din_rise | input | RES | Lanes captured on the rising edge |
| din_fall | input | RES | Lanes captured on the falling edge |
| smp_valid | output | 1 | Output samples are valid this cycle |
| smp_early | output | RES | Reassembled sample, or the earlier of the two samples |
| smp_late | output | RES | Later sample in sample-per-edge format, zero otherwise |

## Verification
Random lane words are applied in both formats. In bit-interleaved format the random words tell apart a correct bit interleave from one with swapped halves or shifted lanes, and the random upper lanes show that those lanes are ignored. Directed all-ones, all-zeros and alternating patterns check the boundaries, where an inverted or constant bit would show. The format select is toggled at random while reset is low, which would expose any reload of the format outside the reset window.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;
   typedef enum logic {
      FMT_BITWISE    = 1'b0,
      FMT_SAMPLEWISE = 1'b1
   } cap_fmt_e;

   function automatic bit res_ok(input int res);
      return (res >= 12) && (res <= 16) && ((res % 2) == 0);
   endfunction
endpackage

// File: rtl/ddr_cap_ctrl.sv
module ddr_cap_ctrl
   import ddr_cap_pkg::*;
(
   input  logic     clk,
   input  logic     srst,
   input  logic     fmt_sel,
   output cap_fmt_e fmt_q,
   output logic     valid_o
);
   logic warm_q;

   always_ff @(posedge clk) begin
      if (srst) begin
         fmt_q   <= cap_fmt_e'(fmt_sel);
         warm_q  <= 1'b0;
         valid_o <= 1'b0;
      end else begin
         warm_q  <= 1'b1;
         valid_o <= warm_q;
      end
   end

   AST_RESET_CLEARS_VALID: assert property (@(posedge clk) srst |=> !valid_o); // R1
   AST_FIRST_CYCLE_QUIET: assert property (@(posedge clk) disable iff (srst)
      $past(srst) |-> !valid_o); // R2
   AST_VALID_CONTINUOUS: assert property (@(posedge clk) disable iff (srst)
      valid_o |=> valid_o); // R7
   AST_FMT_HELD: assert property (@(posedge clk) disable iff (srst)
      !$past(srst) |-> $stable(fmt_q)); // R3
endmodule

// File: rtl/ddr_cap_bitwise.sv
module ddr_cap_bitwise #(
   parameter int RES = 16,
   localparam int HALF = RES / 2
) (
   input  logic [HALF-1:0] lane_rise,
   input  logic [HALF-1:0] lane_fall,
   output logic [RES-1:0]  word_o
);
   for (genvar k = 0; k < HALF; k++) begin : g_lane
      assign word_o[2*k]   = lane_rise[k];
      assign word_o[2*k+1] = lane_fall[k];
   end
endmodule

// File: rtl/ddr_cap_outreg.sv
module ddr_cap_outreg
   import ddr_cap_pkg::*;
#(
   parameter int RES = 16
) (
   input  logic           clk,
   input  logic           srst,
   input  cap_fmt_e       fmt,
   input  logic [RES-1:0] bw_word,
   input  logic [RES-1:0] sw_rise,
   input  logic [RES-1:0] sw_fall,
   output logic [RES-1:0] early_o,
   output logic [RES-1:0] late_o
);
   logic [RES-1:0] early_d, late_d;

   always_comb begin
      if (fmt == FMT_SAMPLEWISE) begin
         early_d = sw_rise;
         late_d  = sw_fall;
      end else begin
         early_d = bw_word;
         late_d  = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (srst) begin
         early_o <= '0;
         late_o  <= '0;
      end else begin
         early_o <= early_d;
         late_o  <= late_d;
      end
   end
endmodule

// File: rtl/ddr_adc_capture.sv
module ddr_adc_capture
   import ddr_cap_pkg::*;
#(
   parameter int RES = 16,
   localparam int HALF = RES / 2
) (
   input  logic           clk,
   input  logic           srst,
   input  logic           fmt_sel,
   input  logic [RES-1:0] din_rise,
   input  logic [RES-1:0] din_fall,
   output logic           smp_valid,
   output logic [RES-1:0] smp_early,
   output logic [RES-1:0] smp_late
);
   if (!res_ok(RES)) begin : g_res_bad
      $error("ddr_adc_capture: RES must be even and within 12..16");
   end

   cap_fmt_e       fmt_q;
   logic [RES-1:0] bw_word;

   ddr_cap_ctrl u_ctrl (
      .clk     (clk),
      .srst    (srst),
      .fmt_sel (fmt_sel),
      .fmt_q   (fmt_q),
      .valid_o (smp_valid)
   );

   ddr_cap_bitwise #(.RES(RES)) u_bitwise (
      .lane_rise (din_rise[HALF-1:0]),
      .lane_fall (din_fall[HALF-1:0]),
      .word_o    (bw_word)
   );

   ddr_cap_outreg #(.RES(RES)) u_outreg (
      .clk     (clk),
      .srst    (srst),
      .fmt     (fmt_q),
      .bw_word (bw_word),
      .sw_rise (din_rise),
      .sw_fall (din_fall),
      .early_o (smp_early),
      .late_o  (smp_late)
   );

   AST_BW_LOW_PAIR: assert property (@(posedge clk) disable iff (srst)
      (smp_valid && fmt_q == FMT_BITWISE) |->
      (smp_early[0] == $past(din_rise[0]) && smp_early[1] == $past(din_fall[0]))); // R4
   AST_BW_TOP_PAIR: assert property (@(posedge clk) disable iff (srst)
      (smp_valid && fmt_q == FMT_BITWISE) |->
      (smp_early[RES-2] == $past(din_rise[HALF-1]) && smp_early[RES-1] == $past(din_fall[HALF-1]))); // R4
   AST_BW_LATE_ZERO: assert property (@(posedge clk) disable iff (srst)
      (smp_valid && fmt_q == FMT_BITWISE) |-> smp_late == '0); // R5
   AST_SW_ORDER: assert property (@(posedge clk) disable iff (srst)
      (smp_valid && fmt_q == FMT_SAMPLEWISE) |->
      (smp_early == $past(din_rise) && smp_late == $past(din_fall))); // R6
endmodule

// File: tb/ddr_adc_capture_tb.sv
`timescale 1ns/1ps
module ddr_adc_capture_tb;
   localparam int RES  = 16;
   localparam int HALF = RES / 2;

   logic           clk = 1'b0;
   logic           srst = 1'b1;
   logic           fmt_sel = 1'b0;
   logic [RES-1:0] din_rise = '0;
   logic [RES-1:0] din_fall = '0;
   logic           smp_valid;
   logic [RES-1:0] smp_early, smp_late;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;
   bit  cur_fmt;
   bit  warm;

   always #2 clk = ~clk;

   ddr_adc_capture #(.RES(RES)) u_dut (
      .clk       (clk),
      .srst      (srst),
      .fmt_sel   (fmt_sel),
      .din_rise  (din_rise),
      .din_fall  (din_fall),
      .smp_valid (smp_valid),
      .smp_early (smp_early),
      .smp_late  (smp_late)
   );

   function automatic logic [RES-1:0] interleave(input logic [RES-1:0] r, input logic [RES-1:0] f);
      logic [RES-1:0] w;
      for (int k = 0; k < HALF; k++) begin
         w[2*k]   = r[k];
         w[2*k+1] = f[k];
      end
      return w;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // enter reset with a format, hold, check cleared outputs, release
   task automatic do_reset(input bit fmt);
      srst    = 1'b1;
      fmt_sel = fmt;
      din_rise = $urandom;
      din_fall = $urandom;
      repeat (3) @(negedge clk);
      chk(smp_valid == 1'b0, "R1 valid", 32'(smp_valid), 0);
      chk(smp_early == '0, "R1 early", 32'(smp_early), 0);
      chk(smp_late == '0, "R1 late", 32'(smp_late), 0);
      cur_fmt = fmt;
      warm    = 1'b0;
      srst    = 1'b0;
   endtask

   // drive one cycle (called at a negedge), check the result at the next negedge
   task automatic step(input logic [RES-1:0] r, input logic [RES-1:0] f, input bit m);
      logic [RES-1:0] exp_e, exp_l;
      bit exp_v;
      din_rise = r;
      din_fall = f;
      fmt_sel  = m;
      exp_v = warm;
      warm  = 1'b1;
      if (cur_fmt) begin
         exp_e = r;
         exp_l = f;
      end else begin
         exp_e = interleave(r, f);
         exp_l = '0;
      end
      @(negedge clk);
      if (!exp_v)
         chk(smp_valid == 1'b0, "R2 first cycle", 32'(smp_valid), 0);
      else begin
         chk(smp_valid == 1'b1, "R7 valid held", 32'(smp_valid), 1);
         if (cur_fmt) begin
            chk(smp_early == exp_e, "R6 early", 32'(smp_early), 32'(exp_e));
            chk(smp_late == exp_l, "R6 late", 32'(smp_late), 32'(exp_l));
         end else begin
            chk(smp_early == exp_e, "R4 interleave", 32'(smp_early), 32'(exp_e));
            chk(smp_late == '0, "R5 late zero", 32'(smp_late), 0);
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      // bit-interleaved format
      do_reset(1'b0);
      step('1, '0, 1'b0);
      step('1, '0, 1'b0);
      step('0, '1, 1'b0);
      step(16'h5555, 16'hAAAA, 1'b0);
      step(16'hFF00, 16'hFF00, 1'b0); // R5: upper lanes only, expect zero word
      for (int i = 0; i < 300; i++)
         step($urandom, $urandom, 1'($urandom)); // R3: fmt_sel toggled, ignored
      // sample-per-edge format
      do_reset(1'b1);
      step('1, '0, 1'b1);
      step('1, '0, 1'b1);
      step(16'hA5A5, 16'h5A5A, 1'b1);
      step('0, '1, 1'b1);
      for (int i = 0; i < 300; i++)
         step($urandom, $urandom, 1'($urandom)); // R3
      // back to bit-interleaved: format reloaded only through reset
      do_reset(1'b0);
      for (int i = 0; i < 50; i++)
         step($urandom, $urandom, 1'b1); // R3
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule